// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache with one way per set. It sits between a processor load/store port and a main memory port that moves one word at a time. Each line stores a valid flag, a tag and a block of four 32-bit words. The processor presents a request and holds it steady while `cpu_stall` is high. An access completes in the first cycle where `cpu_req` is high and `cpu_stall` is low. In that cycle `cpu_rdata` carries the word that was read and `cpu_hit` reports whether the first lookup found the line.

The cache follows a write-through policy. A write hit updates the cached word and writes the same word to memory. On a miss of either kind, the controller first refills the whole block with four sequential word reads. A write miss then merges its word into the new line and writes that word through to memory. All valid flags clear on reset. The number of lines is a parameter, and the default of 16 keeps simulation small.

Top module: `dm_wt_cache`

## Requirements
- R1: Address bits [1:0] are ignored. Bits [3:2] select the word in the block. The next log2(LINES) bits select the line, and the remaining upper bits form the tag. With 16 lines, the index is bits [7:4] and the tag is bits [31:8].
- R2: After reset every line is invalid. With no request pending, `cpu_stall` and `mem_req` are low, and the first access to any line misses.
- R3: A read whose line is valid and whose tag matches completes in its first cycle. `cpu_stall` stays low, `cpu_hit` is 1, no memory request is made, and `cpu_rdata` is the addressed word.
- R4: A read miss issues exactly four memory reads. They start at the block-aligned address and step up one word at a time. Each word is captured when `mem_ready` is high. The access then completes with `cpu_hit` 0 and the requested word.
- R5: A write hit makes exactly one memory write, carrying the processor data to the word-aligned address. The cached word is updated, and `cpu_hit` is 1 at completion.
- R6: A write miss first refills the whole block with four memory reads. It then writes the word to memory and merges it into the line. Later reads of the block return the new word at its offset and memory contents elsewhere. `cpu_hit` is 0 at completion.
- R7: An access whose tag differs from the tag stored at its index replaces that line. A later access to the old tag misses.
- R8: `cpu_stall` is high from the first cycle of a miss or write until the memory work is done. `cpu_hit` is only asserted in a completion cycle.
- R9: `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ready`. Any memory latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid in the completion cycle |
| cpu_stall | output | 1 | Processor must hold its request |
| cpu_hit | output | 1 | Completion cycle of an access that hit |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory transfer finishes this cycle |

## Verification
The assertions check the memory-side protocol on every cycle:
- a request stays stable until `mem_ready`;
- refill addresses are block-aligned and step by one word;
- a write-through carries the processor's word to its own address;
- a completed read never overlaps memory traffic;
- a completed write coincides with its memory acknowledge.

Only the bench's scenarios can show the things that depend on history. These are whether a lookup should hit, given what was loaded before, whether a conflicting tag evicted a line, and whether a merged write-miss block returns the right mix of old and new words.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_stall,
  output logic          cpu_hit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam int BYTE_W  = $clog2(DW / 8);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_LSB = IDX_W + OFF_W + BYTE_W;
  localparam int TAG_W   = AW - TAG_LSB;

  typedef enum logic [1:0] {S_LOOK, S_FILL, S_WRITE} st_t;

  st_t                    st_q;
  logic [LINES-1:0]       valid_q;
  logic [TAG_W-1:0]       tag_q  [LINES];
  logic [DW-1:0]          data_q [LINES*WORDS];
  logic [OFF_W-1:0]       cnt_q;
  logic                   miss_q;

  logic [TAG_W-1:0]       a_tag;
  logic [IDX_W-1:0]       a_idx;
  logic [OFF_W-1:0]       a_off;
  logic                   hit;
  logic [IDX_W+OFF_W-1:0] rd_ix, fill_ix;

  assign a_tag   = cpu_addr[AW-1:TAG_LSB];
  assign a_idx   = cpu_addr[TAG_LSB-1:OFF_W+BYTE_W];
  assign a_off   = cpu_addr[OFF_W+BYTE_W-1:BYTE_W];
  assign hit     = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign rd_ix   = {a_idx, a_off};
  assign fill_ix = {a_idx, cnt_q};

  assign mem_req   = (st_q != S_LOOK);
  assign mem_we    = (st_q == S_WRITE);
  assign mem_wdata = cpu_wdata;
  assign mem_addr  = (st_q == S_WRITE)
                   ? {cpu_addr[AW-1:BYTE_W], {BYTE_W{1'b0}}}
                   : {cpu_addr[AW-1:OFF_W+BYTE_W], cnt_q, {BYTE_W{1'b0}}};

  assign cpu_rdata = data_q[rd_ix];
  assign cpu_stall = cpu_req && ((st_q == S_LOOK) ? !(hit && !cpu_we)
                                                  : !(st_q == S_WRITE && mem_ready));
  assign cpu_hit   = cpu_req && !cpu_stall && !miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_LOOK;
      valid_q <= '0;
      cnt_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      case (st_q)
        S_LOOK: if (cpu_req) begin
          if (hit && !cpu_we) begin
            miss_q <= 1'b0;
          end else if (hit) begin
            st_q <= S_WRITE;
          end else begin
            st_q   <= S_FILL;
            miss_q <= 1'b1;
            cnt_q  <= '0;
          end
        end
        S_FILL: if (mem_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == {OFF_W{1'b1}}) begin
            valid_q[a_idx] <= 1'b1;
            st_q <= cpu_we ? S_WRITE : S_LOOK;
          end
        end
        S_WRITE: if (mem_ready) begin
          st_q   <= S_LOOK;
          miss_q <= 1'b0;
        end
        default: st_q <= S_LOOK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_ready) begin
      data_q[fill_ix] <= mem_rdata;
      if (cnt_q == {OFF_W{1'b1}}) tag_q[a_idx] <= a_tag;
    end else if (st_q == S_WRITE && mem_ready) begin
      data_q[rd_ix] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_stall,
  input logic          cpu_hit,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready
);
  localparam int BW = $clog2(DW / 8);
  localparam int OW = $clog2(WORDS);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  // R5
  wt_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[AW-1:BW] == cpu_addr[AW-1:BW]
                        && mem_addr[BW-1:0] == '0 && mem_wdata == cpu_wdata);

  // R4
  fill_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[AW-1:OW+BW] == cpu_addr[AW-1:OW+BW]
                         && mem_addr[BW-1:0] == '0);

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready && (mem_addr[OW+BW-1:BW] != {OW{1'b1}})
    |=> mem_req && !mem_we
        && mem_addr[OW+BW-1:BW] == OW'($past(mem_addr[OW+BW-1:BW]) + 1'b1));

  // R3
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall && !cpu_we |-> !mem_req);

  // R6
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_stall && cpu_we |-> mem_req && mem_we && mem_ready);

  // R8
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_req && !cpu_stall);
endmodule

bind dm_wt_cache dm_wt_cache_chk #(.WORDS(WORDS), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
  .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/dm_wt_cache_tb_top.sv
module dm_wt_cache_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cpu_req, cpu_we, cpu_stall, cpu_hit;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  dm_wt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .cpu_hit(cpu_hit), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [1024];
  logic [31:0] exp_mem [1024];
  int lat = 0, wait_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  bit seq_bad = 0;
  logic [31:0] first_rd = '0, prev_rd = '0;
  bit ref_v [16];
  logic [23:0] ref_tag [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hC0DE0000 + i * 32'h00010003;
      exp_mem[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) begin
      ref_v[i] = 1'b0;
      ref_tag[i] = '0;
    end
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (rst_n && mem_req) begin
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          mem_ready = 1'b1;
          if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            if (rd_cnt == 0) first_rd = mem_addr;
            else if (mem_addr != prev_rd + 32'd4) seq_bad = 1'b1;
            prev_rd = mem_addr;
            mem_rdata = mem[mem_addr[11:2]];
            rd_cnt++;
          end
        end else wait_cnt++;
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, output bit hit_o);
    bit exp_hit;
    logic [3:0] idx;
    int cyc;
    logic [31:0] got_data;
    string rq;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    rd_cnt = 0; wr_cnt = 0; seq_bad = 1'b0;
    idx = a[7:4];
    exp_hit = ref_v[idx] && ref_tag[idx] == a[31:8];
    cyc = 0;
    #2;
    while (cpu_stall && cyc < 2000) begin
      @(negedge clk);
      #2;
      cyc++;
    end
    hit_o = cpu_hit;
    got_data = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    rq = we ? (exp_hit ? "R5" : "R6") : (exp_hit ? "R3" : "R4");
    chk(hit_o == exp_hit, rq, 32'(hit_o), 32'(exp_hit));
    chk(rd_cnt == (exp_hit ? 0 : 4), rq, rd_cnt, exp_hit ? 0 : 4);
    chk(wr_cnt == (we ? 1 : 0), rq, wr_cnt, we ? 1 : 0);
    if (!exp_hit) begin
      chk(first_rd == {a[31:4], 4'h0} && !seq_bad, "R4", first_rd, {a[31:4], 4'h0});
      // R8 a miss stalls at least one cycle per refill word
      chk(cyc >= 4, "R8", cyc, 4);
    end
    if (!we) begin
      chk(got_data == exp_mem[a[11:2]], rq, got_data, exp_mem[a[11:2]]);
      // R3 hit completes with no stall
      if (exp_hit) chk(cyc == 0, "R3", cyc, 0);
    end else begin
      exp_mem[a[11:2]] = wd;
      chk(mem[a[11:2]] == wd, rq, mem[a[11:2]], wd);
    end
    ref_v[idx] = 1'b1;
    ref_tag[idx] = a[31:8];
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    bit h;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!cpu_stall && !mem_req, "R2", {cpu_stall, mem_req}, 0);

    lat = 2;
    access(1'b0, 32'h004, '0, h);
    chk(!h, "R2", 32'(h), 0);
    // R1 byte offset ignored, word 3 of the same block
    access(1'b0, 32'h00F, '0, h);
    chk(h, "R1", 32'(h), 1);
    access(1'b0, 32'h006, '0, h);
    chk(h, "R1", 32'(h), 1);
    // R7 conflict on index 0
    access(1'b0, 32'h104, '0, h);
    access(1'b0, 32'h008, '0, h);
    chk(!h, "R7", 32'(h), 0);
    // R6 write miss then merged block reads
    access(1'b1, 32'h228, 32'hDEADBEEF, h);
    chk(!h, "R6", 32'(h), 0);
    for (int w = 0; w < 4; w++) begin
      access(1'b0, 32'h220 + 32'(w * 4), '0, h);
      chk(h, "R6", 32'(h), 1);
    end
    // R5 write hit
    access(1'b1, 32'h224, 32'h12345678, h);
    chk(h, "R5", 32'(h), 1);
    access(1'b0, 32'h225, '0, h);
    // R9 long and zero latency
    lat = 6;
    access(1'b0, 32'h350, '0, h);
    access(1'b1, 32'h35C, 32'hA1B2C3D4, h);
    lat = 0;
    access(1'b0, 32'h390, '0, h);
    access(1'b1, 32'h3A4, 32'h0F0F0F0F, h);

    for (int k = 0; k < 400; k++) begin
      lat = $urandom % 4;
      access(($urandom % 3) == 0, $urandom % 1024, $urandom, h);
    end
    summary();
  end
endmodule